// File: doc/BRIEF.md
# Buck Converter Gate-Drive Controller

This block commands the two power switches of a synchronous buck stage: the high-side switch (`hs_en`) and the low-side switch (`ls_en`). Each switch returns an acknowledge that tracks its real state. Three condition inputs drive the sequencing: an under-voltage flag, an over-current flag and a zero-crossing flag. The controller moves between a resting point, where the low-side switch conducts, and a charging point, where the high-side switch conducts. Every move is break-before-make. The controller only enables one switch after the acknowledge of the other switch has been seen low, and it then waits one dead cycle.

A charge can be started in three ways. The first is under-voltage alone. The second is under-voltage followed by a zero-crossing pulse. The third is a zero-crossing that arrives first, so the low-side switch is opened early and the high-side switch waits for under-voltage. In every case the over-current flag later returns the stage to rest. All five inputs pass through two-flop synchronizers. An input sequence that the current state does not allow sets a sticky error and freezes both switch commands until reset. A debug port shows the synchronized levels, the switch commands and which charge path is active.

Top module: `buck_gate_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `ls_en`=1, `hs_en`=0, `err`=0, `dbg_path`=0 and `dbg_state`=7'b0000101.
- R2: Every input passes through two synchronizer flops. A change applied before clock edge k shows on the switch outputs after edge k+2, and not before.
- R3: From rest, under-voltage alone clears `ls_en`. Once `ls_ack` is seen low and one dead cycle has passed, `hs_en` is set. `dbg_path` reads 1 (under-voltage only).
- R4: Once under-voltage has fallen, a rising over-current clears `hs_en`. After `hs_ack` is seen low and one dead cycle, `ls_en` is set. The block returns to rest when over-current falls after `ls_ack` has risen.
- R5: `hs_en` and `ls_en` are never both 1. `hs_en` rises only while the synchronized `ls_ack` is 0, and `ls_en` rises only while the synchronized `hs_ack` is 0. Each rise follows at least two cycles in which both commands were 0.
- R6: A zero-crossing rise during an under-voltage-only charge changes `dbg_path` to 2. Under-voltage falling while zero-crossing is still high is an error.
- R7: A zero-crossing from rest clears `ls_en` and sets `dbg_path` to 3. `hs_en` is held off until under-voltage is also high. Under-voltage may arrive before or after `ls_ack` falls.
- R8: Under-voltage may only fall after `hs_ack` has risen and zero-crossing is low. The zero-crossing fall and the `hs_ack` rise may come in either order, and a fall of both flags in the same cycle is legal.
- R9: `err` is set by any of these: under-voltage and over-current high together; an acknowledge edge that no pending command asked for; over-current rising during a charge or from rest; under-voltage or zero-crossing moving during the over-current phase; over-current falling before `ls_ack` has risen. Once set, `err` stays 1 until reset.
- R10: While `err` is 1, `hs_en`, `ls_en` and `dbg_path` keep their values whatever the inputs do.
- R11: `dbg_state` bits 6 to 0 hold synchronized under-voltage, over-current, zero-crossing, `hs_ack`, `ls_ack`, then `hs_en` and `ls_en`.
- R12: Under-voltage and zero-crossing rising together from rest select path 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| undervolt | input | 1 | Under-voltage flag (asynchronous) |
| overcur | input | 1 | Over-current flag (asynchronous) |
| zerox | input | 1 | Zero-crossing flag (asynchronous) |
| hs_ack | input | 1 | High-side switch is on |
| ls_ack | input | 1 | Low-side switch is on |
| hs_en | output | 1 | High-side switch command |
| ls_en | output | 1 | Low-side switch command |
| err | output | 1 | Sticky illegal-sequence flag |
| dbg_state | output | 7 | Synchronized inputs and commands, order per R11 |
| dbg_path | output | 2 | Active charge path: 0 none, 1 uv only, 2 uv then zc, 3 zc first |

## Verification
The two functions that can meet in one cycle are the under-voltage release check and the zero-crossing tracking. The end of a zero-crossing pulse and the fall of under-voltage can reach the synchronizer outputs on the same edge. The bench provokes this by dropping both flags in the same cycle after the high-side acknowledge is up, and it expects a legal return with no error. It also drops under-voltage alone while zero-crossing is still high and expects `err`. A behavioural model in the bench predicts every output on every clock, so either a wrong error or a missed error is caught in the cycle it happens.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  // bit positions inside the synchronized input vector
  localparam int IDX_UV = 4;
  localparam int IDX_OC = 3;
  localparam int IDX_ZC = 2;
  localparam int IDX_HA = 1;
  localparam int IDX_LA = 0;
  localparam int NUM_IN = 5;

  // rest levels: only the low-side acknowledge is high
  localparam logic [NUM_IN-1:0] IN_REST = 5'b00001;

  typedef enum logic [3:0] {
    ST_REST,      // low side on, waiting for a charge request
    ST_LS_OPEN,   // low side released, waiting for its ack to drop
    ST_GAP_UP,    // dead time before high side
    ST_WAIT_UV,   // zc-first path: low side off, uv still missing
    ST_HS_CLOSE,  // high side commanded, waiting for its ack
    ST_CHARGE,    // high side conducting, waiting for uv release
    ST_WAIT_OC,   // uv released, waiting for over-current
    ST_HS_OPEN,   // high side released, waiting for its ack to drop
    ST_GAP_DN,    // dead time before low side
    ST_LS_CLOSE,  // low side commanded, waiting for its ack
    ST_DRAIN      // low side conducting, waiting for oc release
  } ctrl_state_e;

  typedef enum logic [1:0] {
    PATH_NONE  = 2'd0,
    PATH_UV    = 2'd1,
    PATH_UV_ZC = 2'd2,
    PATH_ZC_UV = 2'd3
  } chg_path_e;

endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  // STAGES synchronizer flops plus one history flop for edge detection
  localparam int LAST = STAGES;

  logic [W-1:0] chain [0:LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= LAST; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i <= LAST; i++) chain[i] <= chain[i-1];
    end
  end

  assign lvl  = chain[LAST-1];
  assign rise = chain[LAST-1] & ~chain[LAST];
  assign fall = ~chain[LAST-1] & chain[LAST];

endmodule

// File: rtl/bgc_fsm.sv
module bgc_fsm
  import bgc_pkg::*;
#(
  parameter int DEAD_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] lvl,
  input  logic [NUM_IN-1:0] rise,
  input  logic [NUM_IN-1:0] fall,
  output logic              hs_en,
  output logic              ls_en,
  output logic              err,
  output logic [1:0]        path
);

  localparam int CW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(DEAD_CYCLES - 1);

  ctrl_state_e st_q, st_n;
  chg_path_e   path_q, path_n;
  logic        hs_q, hs_n, ls_q, ls_n, err_q, err_n;
  logic        used_q, used_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic        bad;
  logic        uv_phase, oc_phase;

  always_comb begin
    uv_phase = (st_q == ST_LS_OPEN) || (st_q == ST_GAP_UP) || (st_q == ST_WAIT_UV) ||
               (st_q == ST_HS_CLOSE) || (st_q == ST_CHARGE);
    oc_phase = (st_q == ST_WAIT_OC) || (st_q == ST_HS_OPEN) || (st_q == ST_GAP_DN) ||
               (st_q == ST_LS_CLOSE) || (st_q == ST_DRAIN);
  end

  always_comb begin
    st_n   = st_q;
    path_n = path_q;
    hs_n   = hs_q;
    ls_n   = ls_q;
    err_n  = err_q;
    used_n = used_q;
    cnt_n  = cnt_q;
    bad    = 1'b0;

    // an acknowledge may only move when the matching command is pending
    if (rise[IDX_HA] && st_q != ST_HS_CLOSE) bad = 1'b1;
    if (fall[IDX_HA] && st_q != ST_HS_OPEN)  bad = 1'b1;
    if (fall[IDX_LA] && st_q != ST_LS_OPEN)  bad = 1'b1;
    if (rise[IDX_LA] && st_q != ST_LS_CLOSE) bad = 1'b1;
    if (lvl[IDX_UV] && lvl[IDX_OC])          bad = 1'b1;

    if (uv_phase) begin
      if (rise[IDX_OC]) bad = 1'b1;
      if (rise[IDX_ZC]) begin
        if (used_q) bad = 1'b1;
        used_n = 1'b1;
        if (path_q == PATH_UV) path_n = PATH_UV_ZC;
      end
      if (fall[IDX_UV] && st_q != ST_CHARGE) bad = 1'b1;
    end

    if (oc_phase) begin
      if (rise[IDX_UV] || rise[IDX_ZC] || fall[IDX_ZC]) bad = 1'b1;
      if (fall[IDX_OC] && st_q != ST_DRAIN) bad = 1'b1;
    end

    unique case (st_q)
      ST_REST: begin
        if (rise[IDX_OC]) begin
          bad = 1'b1;
        end else if (lvl[IDX_UV] || lvl[IDX_ZC]) begin
          st_n   = ST_LS_OPEN;
          ls_n   = 1'b0;
          used_n = lvl[IDX_ZC];
          if (!lvl[IDX_UV])     path_n = PATH_ZC_UV;
          else if (lvl[IDX_ZC]) path_n = PATH_UV_ZC;
          else                  path_n = PATH_UV;
        end
      end
      ST_LS_OPEN: begin
        if (fall[IDX_LA]) begin
          st_n  = ST_GAP_UP;
          cnt_n = CNT_LOAD;
        end
      end
      ST_GAP_UP: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (lvl[IDX_UV]) begin
          st_n = ST_HS_CLOSE;
          hs_n = 1'b1;
        end else begin
          st_n = ST_WAIT_UV;
        end
      end
      ST_WAIT_UV: begin
        if (rise[IDX_UV]) begin
          st_n = ST_HS_CLOSE;
          hs_n = 1'b1;
        end
      end
      ST_HS_CLOSE: begin
        if (rise[IDX_HA]) st_n = ST_CHARGE;
      end
      ST_CHARGE: begin
        if (fall[IDX_UV]) begin
          if (lvl[IDX_ZC]) begin
            bad = 1'b1;
          end else begin
            st_n   = ST_WAIT_OC;
            path_n = PATH_NONE;
            used_n = 1'b0;
          end
        end
      end
      ST_WAIT_OC: begin
        if (rise[IDX_OC]) begin
          st_n = ST_HS_OPEN;
          hs_n = 1'b0;
        end
      end
      ST_HS_OPEN: begin
        if (fall[IDX_HA]) begin
          st_n  = ST_GAP_DN;
          cnt_n = CNT_LOAD;
        end
      end
      ST_GAP_DN: begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else begin
          st_n = ST_LS_CLOSE;
          ls_n = 1'b1;
        end
      end
      ST_LS_CLOSE: begin
        if (rise[IDX_LA]) st_n = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (fall[IDX_OC]) st_n = ST_REST;
      end
      default: st_n = ST_REST;
    endcase

    // an error, new or old, freezes everything
    if (bad || err_q) begin
      st_n   = st_q;
      path_n = path_q;
      hs_n   = hs_q;
      ls_n   = ls_q;
      used_n = used_q;
      cnt_n  = cnt_q;
      err_n  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_REST;
      path_q <= PATH_NONE;
      hs_q   <= 1'b0;
      ls_q   <= 1'b1;
      err_q  <= 1'b0;
      used_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_n;
      path_q <= path_n;
      hs_q   <= hs_n;
      ls_q   <= ls_n;
      err_q  <= err_n;
      used_q <= used_n;
      cnt_q  <= cnt_n;
    end
  end

  assign hs_en = hs_q;
  assign ls_en = ls_q;
  assign err   = err_q;
  assign path  = path_q;

endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl
  import bgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       undervolt,
  input  logic       overcur,
  input  logic       zerox,
  input  logic       hs_ack,
  input  logic       ls_ack,
  output logic       hs_en,
  output logic       ls_en,
  output logic       err,
  output logic [6:0] dbg_state,
  output logic [1:0] dbg_path
);

  logic [NUM_IN-1:0] raw, lvl, rise, fall;

  assign raw = {undervolt, overcur, zerox, hs_ack, ls_ack};

  bgc_sync #(
    .W(NUM_IN),
    .STAGES(SYNC_STAGES),
    .RST_VAL(IN_REST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .din(raw),
    .lvl(lvl),
    .rise(rise),
    .fall(fall)
  );

  bgc_fsm #(
    .DEAD_CYCLES(DEAD_CYCLES)
  ) u_fsm (
    .clk(clk),
    .rst(rst),
    .lvl(lvl),
    .rise(rise),
    .fall(fall),
    .hs_en(hs_en),
    .ls_en(ls_en),
    .err(err),
    .path(dbg_path)
  );

  assign dbg_state = {lvl, hs_en, ls_en};

endmodule

// File: rtl/bgc_checker.sv
module bgc_checker (
  input logic       clk,
  input logic       rst,
  input logic       hs_en,
  input logic       ls_en,
  input logic       err,
  input logic [6:0] dbg_state,
  input logic [1:0] dbg_path
);

  AST_RESET_REST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ls_en && !hs_en && !err && dbg_state == 7'b0000101 && dbg_path == 2'd0)); // R1

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en)); // R5

  AST_HS_NEEDS_LS_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> !$past(dbg_state[2])); // R5

  AST_LS_NEEDS_HS_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en) |-> !$past(dbg_state[3])); // R5

  AST_DEAD_TIME: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_en) || $rose(ls_en)) |-> (!$past(hs_en) && !$past(ls_en) && !$past(hs_en, 2) && !$past(ls_en, 2))); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R9

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    err |=> ($stable(hs_en) && $stable(ls_en) && $stable(dbg_path))); // R10

endmodule

bind buck_gate_ctrl bgc_checker u_chk (
  .clk(clk),
  .rst(rst),
  .hs_en(hs_en),
  .ls_en(ls_en),
  .err(err),
  .dbg_state(dbg_state),
  .dbg_path(dbg_path)
);

// File: tb/buck_gate_ctrl_tb.sv
module buck_gate_ctrl_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic undervolt = 1'b0, overcur = 1'b0, zerox = 1'b0;
  logic hs_ack = 1'b0, ls_ack = 1'b1;
  logic hs_en, ls_en, err;
  logic [6:0] dbg_state;
  logic [1:0] dbg_path;

  always #10 clk = ~clk;  // 50 MHz

  buck_gate_ctrl u_dut (
    .clk(clk), .rst(rst), .undervolt(undervolt), .overcur(overcur), .zerox(zerox),
    .hs_ack(hs_ack), .ls_ack(ls_ack), .hs_en(hs_en), .ls_en(ls_en), .err(err),
    .dbg_state(dbg_state), .dbg_path(dbg_path)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit plant_on = 1'b1;
  bit running = 1'b0;

  // ---------------- power stage stand-in: ack follows command after two cycles
  logic [1:0] p_hs = 2'b00, p_ls = 2'b11;
  always @(negedge clk) begin
    #2;
    if (rst) begin
      p_hs = 2'b00; p_ls = 2'b11;
    end else if (plant_on) begin
      hs_ack = p_hs[1];
      ls_ack = p_ls[1];
      p_hs = {p_hs[0], hs_en};
      p_ls = {p_ls[0], ls_en};
    end
  end

  // ---------------- reference model, stepped once per clock
  localparam int M_REST = 0, M_LSOPEN = 1, M_GAPUP = 2, M_WAITUV = 3, M_HSCLOSE = 4,
                 M_CHARGE = 5, M_WAITOC = 6, M_HSOPEN = 7, M_GAPDN = 8, M_LSCLOSE = 9,
                 M_DRAIN = 10;
  logic [4:0] hist[$];
  int  m_st = M_REST, m_path = 0;
  bit  m_hs = 0, m_ls = 1, m_err = 0, m_used = 0;

  task automatic model_step(input logic [4:0] c, input logic [4:0] p);
    bit uv = c[4], oc = c[3], zc = c[2];
    bit uv_r = c[4] & ~p[4], uv_f = ~c[4] & p[4];
    bit oc_r = c[3] & ~p[3], oc_f = ~c[3] & p[3];
    bit zc_r = c[2] & ~p[2], zc_f = ~c[2] & p[2];
    bit ha_r = c[1] & ~p[1], ha_f = ~c[1] & p[1];
    bit la_r = c[0] & ~p[0], la_f = ~c[0] & p[0];
    bit fault = 0;
    bit charging = m_st inside {M_LSOPEN, M_GAPUP, M_WAITUV, M_HSCLOSE, M_CHARGE};
    bit draining = m_st inside {M_WAITOC, M_HSOPEN, M_GAPDN, M_LSCLOSE, M_DRAIN};
    int ns = m_st, np = m_path;
    bit nh = m_hs, nl = m_ls, nu = m_used;
    if (m_err) return;
    if (ha_r && m_st != M_HSCLOSE) fault = 1;
    if (ha_f && m_st != M_HSOPEN) fault = 1;
    if (la_f && m_st != M_LSOPEN) fault = 1;
    if (la_r && m_st != M_LSCLOSE) fault = 1;
    if (uv && oc) fault = 1;
    if (charging) begin
      if (oc_r) fault = 1;
      if (zc_r) begin
        if (m_used) fault = 1;
        nu = 1;
        if (m_path == 1) np = 2;
      end
      if (uv_f && m_st != M_CHARGE) fault = 1;
    end
    if (draining) begin
      if (uv_r || zc_r || zc_f) fault = 1;
      if (oc_f && m_st != M_DRAIN) fault = 1;
    end
    case (m_st)
      M_REST:
        if (oc_r) fault = 1;
        else if (uv || zc) begin
          ns = M_LSOPEN; nl = 0; nu = zc;
          np = !uv ? 3 : (zc ? 2 : 1);
        end
      M_LSOPEN:  if (la_f) ns = M_GAPUP;
      M_GAPUP:   if (uv) begin ns = M_HSCLOSE; nh = 1; end else ns = M_WAITUV;
      M_WAITUV:  if (uv_r) begin ns = M_HSCLOSE; nh = 1; end
      M_HSCLOSE: if (ha_r) ns = M_CHARGE;
      M_CHARGE:
        if (uv_f) begin
          if (zc) fault = 1;
          else begin ns = M_WAITOC; np = 0; nu = 0; end
        end
      M_WAITOC:  if (oc_r) begin ns = M_HSOPEN; nh = 0; end
      M_HSOPEN:  if (ha_f) ns = M_GAPDN;
      M_GAPDN:   begin ns = M_LSCLOSE; nl = 1; end
      M_LSCLOSE: if (la_r) ns = M_DRAIN;
      M_DRAIN:   if (oc_f) ns = M_REST;
      default:   ns = M_REST;
    endcase
    if (fault) m_err = 1;
    else begin m_st = ns; m_path = np; m_hs = nh; m_ls = nl; m_used = nu; end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      hist = {5'b00001, 5'b00001, 5'b00001, 5'b00001};
      m_st = M_REST; m_path = 0; m_hs = 0; m_ls = 1; m_err = 0; m_used = 0;
    end else begin
      hist.push_front({undervolt, overcur, zerox, hs_ack, ls_ack});
      if (hist.size() > 4) void'(hist.pop_back());
      model_step(hist[2], hist[3]);
    end
    if (running) begin
      logic [11:0] act, exp;
      act = {hs_en, ls_en, err, dbg_path, dbg_state};
      exp = {m_hs, m_ls, m_err, 2'(m_path), hist[1], m_hs, m_ls};
      n_cmp++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s cycle %0d: outputs act=%b exp=%b", cur_req, cyc, act, exp);
      end
    end
  end

  // ---------------- helpers
  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; plant_on = 1'b1;
    undervolt = 0; overcur = 0; zerox = 0; hs_ack = 0; ls_ack = 1;
    step(5);
    rst = 1'b0;
    step(1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic oc_cycle(input string req);
    overcur = 1; step(16);
    check({req, " hs_en off in drain"}, hs_en, 0);
    check({req, " ls_en on in drain"}, ls_en, 1);
    overcur = 0; step(6);
    check({req, " back at rest"}, dbg_state, 7'b0000101);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // ---------------- stimulus
  initial begin
    do_reset();
    running = 1'b1;
    cur_req = "R1";
    check("R1 ls_en after reset", ls_en, 1);
    check("R1 hs_en after reset", hs_en, 0);
    check("R1 err after reset", err, 0);
    check("R1 R11 dbg_state rest code", dbg_state, 7'b0000101);

    // R2 latency and R3 plain under-voltage path
    cur_req = "R2";
    undervolt = 1;
    step(2);
    check("R2 no change after two edges", ls_en, 1);
    step(1);
    check("R2 change after third edge", ls_en, 0);
    cur_req = "R3";
    step(16);
    check("R3 hs_en on", hs_en, 1);
    check("R3 path uv only", dbg_path, 1);
    check("R11 dbg_state while charging", dbg_state, 7'b1001010);
    undervolt = 0; step(6);
    cur_req = "R4";
    oc_cycle("R4");

    // R6 uv then zc pulse
    cur_req = "R6";
    undervolt = 1; step(5);
    zerox = 1; step(4);
    check("R6 path switched to 2", dbg_path, 2);
    step(12);
    zerox = 0; step(4);
    undervolt = 0; step(6);
    check("R6 legal release no err", err, 0);
    oc_cycle("R6");

    // R8 zc and uv falling in the same cycle
    cur_req = "R8";
    undervolt = 1; step(5);
    zerox = 1; step(16);
    zerox = 0; undervolt = 0; step(6);
    check("R8 same-cycle fall legal", err, 0);
    check("R8 path cleared", dbg_path, 0);
    oc_cycle("R8");

    // R7 zc first, uv after ls_ack fall; zc falls before hs_ack rises
    cur_req = "R7";
    zerox = 1; step(12);
    check("R7 ls_en off on zc", ls_en, 0);
    check("R7 hs_en waits for uv", hs_en, 0);
    check("R7 path zc first", dbg_path, 3);
    undervolt = 1; step(4);
    zerox = 0; step(14);
    check("R7 hs_en on after uv", hs_en, 1);
    check("R8 zc fell before hs_ack, no err", err, 0);
    undervolt = 0; step(6);
    oc_cycle("R7");

    // R7 zc first, uv before ls_ack fall
    cur_req = "R7";
    zerox = 1; step(1);
    undervolt = 1; step(16);
    check("R7 uv early hs_en on", hs_en, 1);
    check("R7 uv early path", dbg_path, 3);
    zerox = 0; step(4);
    undervolt = 0; step(6);
    oc_cycle("R7");

    // R12 uv and zc together
    cur_req = "R12";
    undervolt = 1; zerox = 1; step(6);
    check("R12 simultaneous gives path 2", dbg_path, 2);
    step(12);
    zerox = 0; step(3);
    undervolt = 0; step(6);
    oc_cycle("R12");

    // R9 R10 uv and oc together
    cur_req = "R9";
    undervolt = 1; overcur = 1; step(6);
    check("R9 uv+oc sets err", err, 1);
    cur_req = "R10";
    check("R10 ls_en held", ls_en, 1);
    undervolt = 0; step(8);
    check("R10 still frozen", ls_en, 1);
    check("R9 err sticky", err, 1);
    do_reset();

    // R9 spurious ack
    cur_req = "R9";
    plant_on = 0;
    undervolt = 1; step(8);
    hs_ack = 1; step(6);
    check("R9 stray hs_ack sets err", err, 1);
    ls_ack = 0; step(8);
    check("R10 hs_en stays off after error", hs_en, 0);
    do_reset();

    // R6 uv falls while zc high
    cur_req = "R6";
    undervolt = 1; step(4);
    zerox = 1; step(16);
    undervolt = 0; step(6);
    check("R6 uv fall with zc high is err", err, 1);
    check("R10 hs_en held on", hs_en, 1);
    do_reset();

    // R8 uv falls before hs_ack
    cur_req = "R8";
    plant_on = 0;
    undervolt = 1; step(8);
    ls_ack = 0; step(8);
    check("R8 hs_en commanded", hs_en, 1);
    undervolt = 0; step(6);
    check("R8 early uv fall is err", err, 1);
    do_reset();

    running = 1'b0;
    finish_run();
  end

endmodule